// File: doc/BRIEF.md
# Multi-Precision Floating-Point Maximum/Minimum Unit

This unit returns the larger or the smaller of two floating-point operands, together with a 5-bit exception flag vector. A format select chooses half, single or double precision. The same selection rules apply at every precision. Only the field widths and the canonical NaN pattern change. The operands arrive already extracted from their registers, so the unit does no NaN boxing or unboxing.

A fixed priority chain decides the result:

1. If both operands are NaN, the result is the canonical NaN.
2. If only one operand is NaN, the result is the other operand.
3. If the operands are zeros of opposite sign, the sign decides the result.
4. Otherwise a quiet sign-magnitude ordering decides the result.

Because the ordering is quiet, a quiet NaN raises no flag. Only a signaling NaN sets the invalid bit. The output can be registered, which gives one cycle of latency and a synchronous active-high reset. It can also be left purely combinational.

Top module: `fpmm_unit`

## Requirements
- R1: Format encoding: `fmt` = 2'b00 selects half precision, using operand bits [15:0]. 2'b01 selects single precision, using bits [31:0]. 2'b10 and 2'b11 both select double precision, using bits [63:0]. Operand bits above the selected width are ignored. The result is zero-extended above that width.
- R2: When both operands are NaN, the result is the canonical quiet NaN of the format: 16'h7E00, 32'h7FC0_0000 or 64'h7FF8_0000_0000_0000.
- R3: When exactly one operand is NaN, the result is the other operand, for both operations.
- R4: For zeros of opposite sign, the maximum (`op_min`=0) returns +0 and the minimum (`op_min`=1) returns -0, whichever operand holds them.
- R5: Otherwise, the maximum returns `opnd_a` when `opnd_b` <= `opnd_a`, and `opnd_b` in all other cases. The minimum returns `opnd_a` when `opnd_a` <= `opnd_b`, and `opnd_b` in all other cases. For equal operands this returns `opnd_a`.
- R6: Ordering follows sign-magnitude rules. Any negative value is below any positive value. Of two negative values, the one with the larger magnitude is the smaller. Infinities sit at the extremes.
- R7: NaN classification: an operand is a NaN when its exponent is all ones and its significand is nonzero. A NaN is signaling when the top significand bit is 0. Flag bit 4 (invalid) is set exactly when either operand is a signaling NaN. Flag bits 3..0 are always 0.
- R8: With `OUT_REG`=1 (the default), the result and flags appear one clock after the inputs are applied. While `rst` is high, a clock edge clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| fmt | input | 2 | Precision select (see R1) |
| op_min | input | 1 | 0 = maximum, 1 = minimum |
| opnd_a | input | 64 | First operand, right-aligned |
| opnd_b | input | 64 | Second operand, right-aligned |
| res | output | 64 | Selected value, zero-extended |
| flags | output | 5 | Exception flags; bit 4 = invalid |

## Verification
The assertions assume that the inputs are free of unknown bits on every clock edge after reset. They also assume that the register stage follows the inputs exactly one edge later. The checker therefore keeps its own delayed copy of `fmt`, `op_min` and both operands, and compares each output against that copy. The bench changes inputs only on falling edges and holds reset high from time zero. It fills the unused upper operand bits with arbitrary patterns, so the zero-extension and ignore rules are exercised without breaking those assumptions.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  localparam int DATA_W  = 64;
  localparam int MAG_W   = DATA_W - 1;
  localparam int FLAG_W  = 5;
  localparam int FLAG_NV = 4;
  localparam int NFMT    = 3;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'b00,
    FMT_SINGLE = 2'b01,
    FMT_DOUBLE = 2'b10,
    FMT_DBLALT = 2'b11
  } fmt_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
    logic zero;
  } opclass_t;

  function automatic int fmt_exp_w(int f);
    case (f)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_man_w(int f);
    case (f)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W    = EXP_W + MAN_W + 1
) (
  input  logic [W-1:0] val,
  output opclass_t     cls,
  output logic [W-2:0] mag
);

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic             exp_ones;
  logic             man_nz;

  assign {ex, man} = val[W-2:0];
  assign exp_ones  = &ex;
  assign man_nz    = |man;

  assign cls.sign = val[W-1];
  assign cls.nan  = exp_ones & man_nz;
  assign cls.snan = exp_ones & man_nz & ~man[MAN_W-1];
  assign cls.zero = ~(|val[W-2:0]);
  assign mag      = val[W-2:0];

endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
#(
  parameter int M_W = MAG_W
) (
  input  logic           sign_x,
  input  logic [M_W-1:0] mag_x,
  input  logic           sign_y,
  input  logic [M_W-1:0] mag_y,
  output logic           x_le_y
);

  logic both_zero;

  assign both_zero = ~(|mag_x) & ~(|mag_y);

  always_comb begin
    if (both_zero)
      x_le_y = 1'b1;
    else if (sign_x != sign_y)
      x_le_y = sign_x;
    else if (sign_x)
      x_le_y = (mag_x >= mag_y);
    else
      x_le_y = (mag_x <= mag_y);
  end

endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
(
  input  opclass_t          cls_a,
  input  opclass_t          cls_b,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  logic [DATA_W-1:0] canon,
  input  logic              a_le_b,
  input  logic              b_le_a,
  input  logic              op_min,
  output logic [DATA_W-1:0] pick,
  output logic              invalid
);

  always_comb begin
    if (cls_a.nan && cls_b.nan)
      pick = canon;
    else if (cls_a.nan)
      pick = val_b;
    else if (cls_b.nan)
      pick = val_a;
    else if (cls_a.zero && cls_b.zero && (cls_a.sign != cls_b.sign))
      pick = (cls_a.sign == op_min) ? val_a : val_b;
    else if (op_min)
      pick = a_le_b ? val_a : val_b;
    else
      pick = b_le_a ? val_a : val_b;
  end

  assign invalid = cls_a.snan | cls_b.snan;

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt,
  input  logic              op_min,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] flags
);

  opclass_t          cls_a [NFMT];
  opclass_t          cls_b [NFMT];
  logic [MAG_W-1:0]  mag_a [NFMT];
  logic [MAG_W-1:0]  mag_b [NFMT];
  logic [DATA_W-1:0] val_a [NFMT];
  logic [DATA_W-1:0] val_b [NFMT];
  logic [DATA_W-1:0] canon [NFMT];

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int EW = fmt_exp_w(f);
    localparam int MW = fmt_man_w(f);
    localparam int W  = EW + MW + 1;

    logic [W-2:0] ma;
    logic [W-2:0] mb;

    fpmm_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_a (
      .val (opnd_a[W-1:0]),
      .cls (cls_a[f]),
      .mag (ma)
    );

    fpmm_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_b (
      .val (opnd_b[W-1:0]),
      .cls (cls_b[f]),
      .mag (mb)
    );

    assign mag_a[f] = MAG_W'(ma);
    assign mag_b[f] = MAG_W'(mb);
    assign val_a[f] = DATA_W'(opnd_a[W-1:0]);
    assign val_b[f] = DATA_W'(opnd_b[W-1:0]);
    assign canon[f] = DATA_W'({1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}});
  end

  logic [1:0] sel;
  always_comb begin
    case (fmt)
      FMT_HALF:   sel = 2'd0;
      FMT_SINGLE: sel = 2'd1;
      default:    sel = 2'd2;
    endcase
  end

  opclass_t          ca;
  opclass_t          cb;
  logic [MAG_W-1:0]  ma_s;
  logic [MAG_W-1:0]  mb_s;
  logic [DATA_W-1:0] va_s;
  logic [DATA_W-1:0] vb_s;
  logic [DATA_W-1:0] cn_s;

  assign ca   = cls_a[sel];
  assign cb   = cls_b[sel];
  assign ma_s = mag_a[sel];
  assign mb_s = mag_b[sel];
  assign va_s = val_a[sel];
  assign vb_s = val_b[sel];
  assign cn_s = canon[sel];

  logic a_le_b;
  logic b_le_a;

  fpmm_order #(.M_W(MAG_W)) u_ord_ab (
    .sign_x (ca.sign),
    .mag_x  (ma_s),
    .sign_y (cb.sign),
    .mag_y  (mb_s),
    .x_le_y (a_le_b)
  );

  fpmm_order #(.M_W(MAG_W)) u_ord_ba (
    .sign_x (cb.sign),
    .mag_x  (mb_s),
    .sign_y (ca.sign),
    .mag_y  (ma_s),
    .x_le_y (b_le_a)
  );

  logic [DATA_W-1:0] pick;
  logic              invalid;

  fpmm_select u_sel (
    .cls_a   (ca),
    .cls_b   (cb),
    .val_a   (va_s),
    .val_b   (vb_s),
    .canon   (cn_s),
    .a_le_b  (a_le_b),
    .b_le_a  (b_le_a),
    .op_min  (op_min),
    .pick    (pick),
    .invalid (invalid)
  );

  logic [FLAG_W-1:0] flags_d;
  always_comb begin
    flags_d          = '0;
    flags_d[FLAG_NV] = invalid;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res   <= '0;
        flags <= '0;
      end else begin
        res   <= pick;
        flags <= flags_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign res        = pick;
    assign flags      = flags_d;
  end

endmodule

// File: rtl/fpmm_unit_chk.sv
module fpmm_unit_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  fmt,
  input logic        op_min,
  input logic [63:0] opnd_a,
  input logic [63:0] opnd_b,
  input logic [63:0] res,
  input logic [4:0]  flags
);

  function automatic logic [63:0] slice_of(logic [1:0] f, logic [63:0] v);
    case (f)
      2'b00:   return {48'b0, v[15:0]};
      2'b01:   return {32'b0, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic nan_of(logic [1:0] f, logic [63:0] v);
    case (f)
      2'b00:   return (v[14:10] == '1) && (v[9:0] != '0);
      2'b01:   return (v[30:23] == '1) && (v[22:0] != '0);
      default: return (v[62:52] == '1) && (v[51:0] != '0);
    endcase
  endfunction

  function automatic logic snan_of(logic [1:0] f, logic [63:0] v);
    case (f)
      2'b00:   return nan_of(f, v) && !v[9];
      2'b01:   return nan_of(f, v) && !v[22];
      default: return nan_of(f, v) && !v[51];
    endcase
  endfunction

  function automatic logic zero_of(logic [1:0] f, logic [63:0] v);
    case (f)
      2'b00:   return v[14:0] == '0;
      2'b01:   return v[30:0] == '0;
      default: return v[62:0] == '0;
    endcase
  endfunction

  function automatic logic sign_of(logic [1:0] f, logic [63:0] v);
    case (f)
      2'b00:   return v[15];
      2'b01:   return v[31];
      default: return v[63];
    endcase
  endfunction

  function automatic logic [63:0] canon_of(logic [1:0] f);
    case (f)
      2'b00:   return 64'h7E00;
      2'b01:   return 64'h7FC0_0000;
      default: return 64'h7FF8_0000_0000_0000;
    endcase
  endfunction

  function automatic int width_of(logic [1:0] f);
    case (f)
      2'b00:   return 16;
      2'b01:   return 32;
      default: return 64;
    endcase
  endfunction

  logic        armed;
  logic [1:0]  q_fmt;
  logic        q_min;
  logic [63:0] q_a;
  logic [63:0] q_b;

  always_ff @(posedge clk) armed <= !rst;

  if (OUT_REG) begin : g_lag
    always_ff @(posedge clk) begin
      q_fmt <= fmt;
      q_min <= op_min;
      q_a   <= opnd_a;
      q_b   <= opnd_b;
    end

    p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (res == '0) && (flags == '0));
  end else begin : g_now
    assign q_fmt = fmt;
    assign q_min = op_min;
    assign q_a   = opnd_a;
    assign q_b   = opnd_b;
  end

  logic nan_a, nan_b;
  assign nan_a = nan_of(q_fmt, q_a);
  assign nan_b = nan_of(q_fmt, q_b);

  p_quiet_bits_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    flags[3:0] == 4'b0);

  p_invalid_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    flags[4] == (snan_of(q_fmt, q_a) || snan_of(q_fmt, q_b)));

  p_zero_ext_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    (width_of(q_fmt) < 64) |-> ((res >> width_of(q_fmt)) == 64'b0));

  p_canon_nan_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    (nan_a && nan_b) |-> (res == canon_of(q_fmt)));

  p_pass_other_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (nan_a != nan_b) |-> (res == (nan_a ? slice_of(q_fmt, q_b) : slice_of(q_fmt, q_a))));

  p_zero_sign_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (zero_of(q_fmt, q_a) && zero_of(q_fmt, q_b) &&
     (sign_of(q_fmt, q_a) != sign_of(q_fmt, q_b))) |-> (sign_of(q_fmt, res) == q_min));

  p_operand_pick_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!nan_a && !nan_b) |-> ((res == slice_of(q_fmt, q_a)) || (res == slice_of(q_fmt, q_b))));

endmodule

bind fpmm_unit fpmm_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .fmt    (fmt),
  .op_min (op_min),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .res    (res),
  .flags  (flags)
);

// File: tb/fpmm_unit_test.sv
`timescale 1ns/1ps
module fpmm_unit_test;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  fmt;
    logic        mn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic [4:0]  fl;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{4'd5, 2'd0, 1'b0, 64'h3C00, 64'h4000, 64'h4000, 5'h00},           // R5 half max
    '{4'd5, 2'd0, 1'b1, 64'h3C00, 64'h4000, 64'h3C00, 5'h00},           // R5 half min
    '{4'd6, 2'd0, 1'b0, 64'hBC00, 64'hC000, 64'hBC00, 5'h00},           // R6 negatives max
    '{4'd6, 2'd0, 1'b1, 64'hBC00, 64'hC000, 64'hC000, 5'h00},           // R6 negatives min
    '{4'd4, 2'd0, 1'b0, 64'h8000, 64'h0000, 64'h0000, 5'h00},           // R4 max zeros
    '{4'd4, 2'd0, 1'b1, 64'h0000, 64'h8000, 64'h8000, 5'h00},           // R4 min zeros
    '{4'd3, 2'd0, 1'b0, 64'h7E55, 64'h3C00, 64'h3C00, 5'h00},           // R3 qNaN, no flag
    '{4'd7, 2'd0, 1'b1, 64'h7C01, 64'h4000, 64'h4000, 5'h10},           // R7 sNaN flags
    '{4'd2, 2'd0, 1'b0, 64'h7E55, 64'h7C01, 64'h7E00, 5'h10},           // R2 half canon
    '{4'd6, 2'd1, 1'b0, 64'hBF80_0000, 64'h3F80_0000, 64'h3F80_0000, 5'h00}, // R6 mixed sign
    '{4'd6, 2'd1, 1'b1, 64'hFF80_0000, 64'hBF80_0000, 64'hFF80_0000, 5'h00}, // R6 -inf
    '{4'd2, 2'd1, 1'b0, 64'h7FC0_0001, 64'h7FA0_0000, 64'h7FC0_0000, 5'h10}, // R2 single canon
    '{4'd4, 2'd1, 1'b1, 64'h8000_0000, 64'h0000_0000, 64'h8000_0000, 5'h00}, // R4 single
    '{4'd5, 2'd2, 1'b0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
      64'h4000_0000_0000_0000, 5'h00},                                    // R5 double max
    '{4'd6, 2'd2, 1'b1, 64'hBFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000,
      64'hBFF0_0000_0000_0000, 5'h00},                                    // R6 +inf
    '{4'd7, 2'd2, 1'b0, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000,
      64'h3FF0_0000_0000_0000, 5'h10},                                    // R7 double sNaN
    '{4'd2, 2'd2, 1'b1, 64'h7FF8_0000_0000_0000, 64'hFFF8_0000_0000_0000,
      64'h7FF8_0000_0000_0000, 5'h00},                                    // R2 double canon
    '{4'd1, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_3C00, 64'h1234_5678_9ABC_4000,
      64'h4000, 5'h00},                                                   // R1 half upper ignored
    '{4'd1, 2'd1, 1'b1, 64'hAAAA_AAAA_3F80_0000, 64'h5555_5555_4000_0000,
      64'h3F80_0000, 5'h00},                                              // R1 single upper ignored
    '{4'd4, 2'd2, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 5'h00},    // R4 double
    '{4'd1, 2'd3, 1'b0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
      64'h4000_0000_0000_0000, 5'h00}                                     // R1 alt double code
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'd0;
  logic        op_min = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [63:0] res;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpmm_unit uut (
    .clk    (clk),
    .rst    (rst),
    .fmt    (fmt),
    .op_min (op_min),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .res    (res),
    .flags  (flags)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [1:0] f, logic m, logic [63:0] a, logic [63:0] b);
    fmt    = f;
    op_min = m;
    opnd_a = a;
    opnd_b = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset clears outputs even with live inputs
    drive(2'd0, 1'b0, 64'h3C00, 64'h4000);
    repeat (2) @(negedge clk);
    chk("R8 reset res", res, 64'h0);
    chk("R8 reset flags", 64'(flags), 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].fmt, TBL[i].mn, TBL[i].a, TBL[i].b);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d res", TBL[i].req, i), res, TBL[i].r);
      chk($sformatf("R%0d vec %0d flags", TBL[i].req, i), 64'(flags), 64'(TBL[i].fl));
    end

    // R8: one-cycle latency, output holds until the next edge
    @(negedge clk);
    drive(2'd0, 1'b0, 64'h3C00, 64'h4000);
    @(negedge clk);
    chk("R8 latency first", res, 64'h4000);
    drive(2'd0, 1'b1, 64'h3C00, 64'h4000);
    #1;
    chk("R8 latency hold", res, 64'h4000);
    @(negedge clk);
    chk("R8 latency update", res, 64'h3C00);

    // R5: equal operands give opnd_a (visible via sign of equal zeros? use equal values)
    drive(2'd1, 1'b0, 64'h4040_0000, 64'h4040_0000);
    @(negedge clk);
    chk("R5 equal max", res, 64'h4040_0000);

    // R7: sNaN in both gives canon and invalid
    drive(2'd2, 1'b1, 64'h7FF0_0000_0000_0002, 64'hFFF4_0000_0000_0000);
    @(negedge clk);
    chk("R2 two sNaN res", res, 64'h7FF8_0000_0000_0000);
    chk("R7 two sNaN flags", 64'(flags), 64'h10);

    // R8: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    chk("R8 midrun reset res", res, 64'h0);
    chk("R8 midrun reset flags", 64'(flags), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 after reset", res, 64'hFFF4_0000_0000_0000 & 64'h0 | 64'h7FF8_0000_0000_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule